// File: doc/BRIEF.md
# Clock-Gap Second Marker Receiver

This block sits on the receiving end of a distributed clock line whose sender marks the start of every second by holding the clock at zero for a short while. The block samples the distributed clock with a free-running local clock that is fast enough to see every level. It detects such a gap as a run of low samples longer than any normal low phase. It then raises a one-cycle second marker on the local clock in the cycle that follows the first high sample after the gap. No processing path of variable length lies between that rising edge and the marker, so the marker's position relative to the edge is fixed.

A second state machine measures the spacing between markers against a nominal count of local cycles per second, within a symmetric tolerance. A marker that arrives too soon raises a one-cycle early flag. If no marker comes within the window, a one-cycle missing flag is raised and the checker waits for the next marker to start timing again. A low stretch already under way when reset is released is never taken as a gap.

The gap detector has three states. GS_ARM waits for the first high sample after reset and then moves to GS_RUN. GS_RUN counts consecutive low samples, clears the count on a high sample, and moves to GS_GAP on the low sample that brings the run to the threshold. GS_GAP waits for a high sample, issues the marker and goes back to GS_RUN. The interval checker has two states. IV_IDLE moves to IV_TIME on a marker. IV_TIME restarts its count on every marker and drops back to IV_IDLE when the late limit passes without a marker.

Top module: `pps_gap_marker`

## Requirements
- R1: The distributed clock passes through two synchroniser flops before detection. A first high sample captured at the pin on local edge n gives pps_o high in the cycle after edge n+2, which is a constant offset of three edges.
- R2: A gap is declared only after GAP_MIN consecutive low samples. A low run of GAP_MIN-1 samples followed by a high sample gives no marker.
- R3: For each gap, pps_o is high for exactly one cycle, placed on the first high sample after the gap as in R1, whatever the gap's length beyond the threshold.
- R4: After reset is released, nothing counts toward a gap until the first high sample has been seen. A low stretch already in progress at release never produces a marker.
- R5: Normal toggling whose low runs are shorter than GAP_MIN never produces a marker.
- R6: The interval between two markers is the number of local cycles between their pps_o pulses. If this interval is less than NOM_CYCLES-TOL_CYCLES, early_o is high for one cycle, in the cycle after the later pps_o pulse.
- R7: An interval from NOM_CYCLES-TOL_CYCLES to NOM_CYCLES+TOL_CYCLES, both limits included, raises neither flag.
- R8: If no marker follows a marker within NOM_CYCLES+TOL_CYCLES cycles, missing_o is high for one cycle, NOM_CYCLES+TOL_CYCLES+1 cycles after that marker's pps_o cycle. Timing then stops until the next marker, which is not checked. No missing flag is raised before the first marker after reset.
- R9: While rst_ni is low, pps_o, early_o and missing_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oversampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| dclk_i | input | 1 | Distributed clock line, asynchronous to clk_i |
| pps_o | output | 1 | One-cycle second marker |
| early_o | output | 1 | One-cycle flag: marker came before the tolerance window |
| missing_o | output | 1 | One-cycle flag: no marker within the tolerance window |

## Verification
The assertions assume that the local clock samples every level of the distributed clock, and that normal low phases stay well below GAP_MIN, so that only a deliberate gap can reach the threshold. They also assume that a marker and a later rising edge cannot fall in adjacent cycles. This holds because a gap always needs at least GAP_MIN low samples before the next marker can fire. The stimulus keeps normal low and high runs between one and three samples and makes every gap at least GAP_MIN long. The only exception is the one deliberate near-gap of GAP_MIN-1 low samples. Gap starts and second lengths are placed so that each marker lands on an exact, chosen sample index.

// File: rtl/pps_gap_pkg.sv
package pps_gap_pkg;

    typedef enum logic [1:0] {
        GS_ARM = 2'd0,
        GS_RUN = 2'd1,
        GS_GAP = 2'd2
    } gap_state_t;

    typedef enum logic {
        IV_IDLE = 1'b0,
        IV_TIME = 1'b1
    } ivl_state_t;

endpackage

// File: rtl/pps_sync2.sv
module pps_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pps_gap_detect.sv
module pps_gap_detect
    import pps_gap_pkg::*;
#(
    parameter int GAP_MIN = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic s_i,
    output logic pps_o
);
    localparam int CW = $clog2(GAP_MIN + 1);
    localparam logic [CW-1:0] LAST_LOW = CW'(GAP_MIN - 1);

    gap_state_t state_q, state_d;
    logic [CW-1:0] low_q, low_d;
    logic pps_q;

    // next-state and low-run count
    always_comb begin
        state_d = state_q;
        low_d   = low_q;
        unique case (state_q)
            GS_ARM: begin
                low_d = '0;
                if (s_i) state_d = GS_RUN;
            end
            GS_RUN: begin
                if (s_i) begin
                    low_d = '0;
                end else if (low_q == LAST_LOW) begin
                    state_d = GS_GAP;
                    low_d   = '0;
                end else begin
                    low_d = low_q + 1'b1;
                end
            end
            GS_GAP: begin
                low_d = '0;
                if (s_i) state_d = GS_RUN;
            end
            default: begin
                state_d = GS_ARM;
                low_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= GS_ARM;
            low_q   <= '0;
        end else begin
            state_q <= state_d;
            low_q   <= low_d;
        end
    end

    // output register: marker on first high sample while in GS_GAP
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pps_q <= 1'b0;
        end else begin
            pps_q <= (state_q == GS_GAP) && s_i;
        end
    end

    assign pps_o = pps_q;

    // R3: a marker follows a low-to-high transition of the synchronised line
    p_marker_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pps_q |-> ($past(s_i) && !$past(s_i, 2)));

    // R3: marker lasts one cycle only
    p_marker_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pps_q |=> !pps_q);
endmodule

// File: rtl/pps_interval_check.sv
module pps_interval_check
    import pps_gap_pkg::*;
#(
    parameter int NOM_CYCLES = 250_000_000,
    parameter int TOL_CYCLES = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pps_i,
    output logic early_o,
    output logic missing_o
);
    localparam int EARLY_LIM = NOM_CYCLES - TOL_CYCLES;
    localparam int LATE_LIM  = NOM_CYCLES + TOL_CYCLES;
    localparam int CW        = $clog2(LATE_LIM + 1);
    localparam logic [CW-1:0] EARLY_CMP = CW'(EARLY_LIM - 1);
    localparam logic [CW-1:0] LATE_CMP  = CW'(LATE_LIM - 1);

    ivl_state_t state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic early_q, missing_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IV_IDLE: if (pps_i) state_d = IV_TIME;
            IV_TIME: if (!pps_i && cnt_q == LATE_CMP) state_d = IV_IDLE;
            default: state_d = IV_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= IV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // counter and flags
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q     <= '0;
            early_q   <= 1'b0;
            missing_q <= 1'b0;
        end else begin
            early_q   <= (state_q == IV_TIME) && pps_i && (cnt_q < EARLY_CMP);
            missing_q <= (state_q == IV_TIME) && !pps_i && (cnt_q == LATE_CMP);
            if (pps_i) begin
                cnt_q <= '0;
            end else if (state_q == IV_TIME && cnt_q != LATE_CMP) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign early_o   = early_q;
    assign missing_o = missing_q;

    // R6: an early flag always follows a marker
    p_early_after_marker_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        early_q |-> $past(pps_i));

    // R8: a missing flag never follows a marker directly
    p_missing_no_marker_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        missing_q |-> !$past(pps_i));

    // R7: the two flags never coincide
    p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(early_q && missing_q));
endmodule

// File: rtl/pps_gap_marker.sv
module pps_gap_marker #(
    parameter int GAP_MIN    = 16,
    parameter int NOM_CYCLES = 250_000_000,
    parameter int TOL_CYCLES = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dclk_i,
    output logic pps_o,
    output logic early_o,
    output logic missing_o
);
    logic dclk_s;
    logic pps_w;

    // R1: two-flop synchroniser, fixed latency of two local edges
    pps_sync2 #(.STAGES(2)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (dclk_i),
        .q_o    (dclk_s)
    );

    pps_gap_detect #(.GAP_MIN(GAP_MIN)) u_detect (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .s_i    (dclk_s),
        .pps_o  (pps_w)
    );

    pps_interval_check #(
        .NOM_CYCLES (NOM_CYCLES),
        .TOL_CYCLES (TOL_CYCLES)
    ) u_ivl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pps_i     (pps_w),
        .early_o   (early_o),
        .missing_o (missing_o)
    );

    assign pps_o = pps_w;
endmodule

// File: tb/pps_gap_marker_tb.sv
module pps_gap_marker_tb_top;
    localparam int GMIN = 8;
    localparam int NOM  = 300;
    localparam int TOL  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dclk = 1'b0;
    logic pps, early, missing;

    always #2 clk = ~clk;

    pps_gap_marker #(.GAP_MIN(GMIN), .NOM_CYCLES(NOM), .TOL_CYCLES(TOL)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dclk_i(dclk),
        .pps_o(pps), .early_o(early), .missing_o(missing)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string req = "R9";
    bit done = 0;

    // bench model state
    bit armed = 0;
    int lowrun = 0;
    bit have_last = 0;
    int last_o = 0;
    int due_pps = -1, due_early = -1, due_miss = -1, due_miss_old = -1;
    int n_sched = 0, n_seen = 0;
    bit lvl = 0;
    int run_left = 0;

    function automatic bit early_expected(int iv);
        return iv < NOM - TOL;
    endfunction

    task automatic chk(string r, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at sample %0d: got %0b expected %0b", r, what, cyc, act, exp);
        end
    endtask

    task automatic schedule(int o);
        if (have_last && early_expected(o - last_o)) due_early = o + 1;
        if (due_miss >= cyc && due_miss <= o) due_miss_old = due_miss;
        due_miss = o + NOM + TOL + 1;
        due_pps = o;
        last_o = o;
        have_last = 1;
        n_sched++;
    endtask

    // one local cycle: check outputs, then drive next sample
    task automatic step(bit v);
        @(negedge clk);
        cyc++;
        if (pps) n_seen++;
        chk(req, pps, cyc == due_pps, "pps_o");
        chk(req, early, cyc == due_early, "early_o");
        chk(req, missing, (cyc == due_miss) || (cyc == due_miss_old), "missing_o");
        dclk = v;
        if (rst_n) begin
            if (v) begin
                if (armed && lowrun >= GMIN) schedule(cyc + 3);
                armed = 1;
                lowrun = 0;
            end else if (armed) begin
                lowrun++;
            end
        end
    endtask

    task automatic normal(int count);
        for (int i = 0; i < count; i++) begin
            if (run_left == 0) begin
                lvl = ~lvl;
                run_left = 1 + int'($urandom_range(0, 2));
            end
            step(lvl);
            run_left--;
        end
    endtask

    // marker's first high sample lands on index n_target
    task automatic emit_second(int n_target, int g);
        normal(n_target - cyc - 2 - g);
        step(1'b1);
        for (int i = 0; i < g; i++) step(1'b0);
        step(1'b1);
        lvl = 1'b1;
        run_left = 1;
    endtask

    task automatic do_reset(int cycles);
        req = "R9";
        @(negedge clk);
        rst_n = 1'b0;
        dclk = 1'b0;
        armed = 0; lowrun = 0; have_last = 0;
        due_pps = -1; due_early = -1; due_miss = -1; due_miss_old = -1;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            cyc++;
            chk("R9", pps, 1'b0, "pps_o in reset");
            chk("R9", early, 1'b0, "early_o in reset");
            chk("R9", missing, 1'b0, "missing_o in reset");
        end
        rst_n = 1'b1;
    endtask

    initial begin
        int base;
        void'($urandom(32'd4242));
        do_reset(6);
        // R4: line still low at release, then normal toggling: no marker
        req = "R4";
        for (int i = 0; i < 25; i++) step(1'b0);
        normal(30);
        // R1: first marker, exact placement; no missing before it (R8)
        req = "R1";
        emit_second(cyc + 40, GMIN);
        base = cyc;
        // R7: nominal interval
        req = "R7";
        emit_second(base + NOM, GMIN + 3);
        emit_second(cyc + NOM - TOL, GMIN);
        emit_second(cyc + NOM + TOL, GMIN + 12);
        // R6: one cycle too soon
        req = "R6";
        emit_second(cyc + NOM - TOL - 1, GMIN);
        emit_second(cyc + NOM / 2, GMIN + 5);
        // R2: near-gap of GMIN-1 lows inside a second, then exact GMIN gap
        req = "R2";
        base = cyc;
        normal(20);
        step(1'b1);
        for (int i = 0; i < GMIN - 1; i++) step(1'b0);
        step(1'b1);
        lvl = 1'b1; run_left = 1;
        emit_second(base + NOM, GMIN);
        // R3, R5: random second lengths and gap lengths
        req = "R3";
        for (int k = 0; k < 10; k++) begin
            int iv = NOM - TOL - 4 + int'($urandom_range(0, 2 * TOL + 4));
            int g  = GMIN + int'($urandom_range(0, 20));
            emit_second(cyc + iv, g);
        end
        req = "R5";
        normal(NOM / 2);
        // R8: marker silence past the window, then recovery
        req = "R8";
        normal(NOM + TOL + 40);
        emit_second(cyc + 30, GMIN);
        emit_second(cyc + NOM, GMIN);
        emit_second(cyc + NOM + TOL + 1, GMIN + 2);
        emit_second(cyc + NOM, GMIN);
        // R4: reset in the middle of a gap
        for (int i = 0; i < 5; i++) step(1'b0);
        do_reset(3);
        req = "R4";
        for (int i = 0; i < 15; i++) step(1'b0);
        step(1'b1);
        normal(20);
        emit_second(cyc + 50, GMIN);
        emit_second(cyc + NOM, GMIN);
        normal(10);
        chk("R3", n_seen == n_sched, 1'b1, "marker count matches");
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at sample %0d: got timeout expected completion", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule